// File: doc/BRIEF.md
# GPIO Edge Capture and Interrupt Combiner

This block watches a wide set of general-purpose pins, arranged as banks of 32, and records rising and falling transitions as sticky status bits. Each pin has its own rising-edge and falling-edge enable. A pin whose direction control marks it as an output never records an edge. Software clears recorded events by writing ones to a bank's status bits, and the block keeps any event that arrives in the same cycle as the clear.

The status is combined into three level interrupts. Pin 0 and pin 1 each drive a line of their own. Every other status bit, across all banks, is ORed into one shared line. The block also produces a one-cycle wake request. It fires when the processor reports that it is halted and an input pin from a fixed set of wake-capable pins changes level. Pin inputs pass through a two-flop synchronizer before any comparison. Pins at or above the configured line count are treated as absent.

Top module: `gpio_edge_irq`

## Requirements
- R1: A pin whose rising enable is set and whose direction bit is 0 (input) sets its status bit when its synchronized level goes from 0 to 1. A pin change driven before clock edge E0 appears on `status_out` after edge E2, which is the third rising edge.
- R2: A pin whose falling enable is set and whose direction bit is 0 sets its status bit when its synchronized level goes from 1 to 0. The latency is the same as in R1.
- R3: A pin whose direction bit is 1 (output) never sets its status bit, whatever its enables are.
- R4: When `clr_valid` is high, each 1 in `clr_mask` clears the matching status bit of bank `clr_bank` (bank b covers pins 32*b to 32*b+31) on the next edge. Bits written as 0, and all other banks, are left unchanged.
- R5: When a clear and a new edge event hit the same status bit in the same cycle, the bit stays set.
- R6: `irq_pin0` and `irq_pin1` equal status bits 0 and 1 as they were one cycle earlier.
- R7: `irq_shared` equals the OR of status bits 2 and above as they were one cycle earlier.
- R8: `wake_req` pulses for one cycle, at the same edge the status would update, when `halted` is high and an input pin changes level. The pin must be in the wake set: bank masks 0x8003FE1B, 0x002001FC, 0xEC080000 and 0x0012007F for banks 0 to 3, where bit i is pin 32*b+i. A change on any other pin, a change while `halted` is low, and a change on a pin configured as an output give no pulse.
- R9: Pins with index at or above `NUM_LINES` (default 121) never set status and never request wake.
- R10: After reset, all status bits, all three interrupts and `wake_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 128 | Asynchronous pin levels |
| pin_dir | input | 128 | Direction per pin, 1 = output |
| rise_en | input | 128 | Rising-edge capture enable per pin |
| fall_en | input | 128 | Falling-edge capture enable per pin |
| clr_valid | input | 1 | Clear request strobe |
| clr_bank | input | 2 | Bank addressed by the clear |
| clr_mask | input | 32 | Write-one-to-clear mask |
| halted | input | 1 | Processor halted indication |
| status_out | output | 128 | Captured edge status |
| irq_pin0 | output | 1 | Interrupt for pin 0 |
| irq_pin1 | output | 1 | Interrupt for pin 1 |
| irq_shared | output | 1 | Interrupt for all other pins |
| wake_req | output | 1 | One-cycle wake pulse |

## Verification
If the previous-sample register held a wrong value, the next cycle would show a spurious or missing status bit. That bit appears on `status_out` one edge later, and the wrong level reaches an interrupt line one edge after that. A mistake in the clear path shows on `status_out` on the edge after the strobe. The tests target the priority of an edge over a clear in the same cycle, direction gating, the unused pins above the line count, and each condition that blocks a wake request.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

    localparam int BANK_W    = 32;
    localparam int DEF_BANKS = 4;

    typedef logic [BANK_W-1:0] bank_vec_t;

    typedef struct packed {
        bank_vec_t rise;
        bank_vec_t fall;
    } edge_evt_t;

    // Pins able to wake a halted processor, one mask per bank.
    function automatic bank_vec_t wake_set(input int bank);
        case (bank)
            0:       return 32'h8003_FE1B;
            1:       return 32'h0020_01FC;
            2:       return 32'hEC08_0000;
            3:       return 32'h0012_007F;
            default: return '0;
        endcase
    endfunction

    // Bits of a bank that map to implemented pins.
    function automatic bank_vec_t present_set(input int bank, input int lines);
        bank_vec_t m;
        for (int i = 0; i < BANK_W; i++) begin
            m[i] = ((bank * BANK_W + i) < lines);
        end
        return m;
    endfunction

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
    import gpio_edge_pkg::*;
#(
    parameter int BANK_IDX  = 0,
    parameter int NUM_LINES = 121
) (
    input  logic      clk,
    input  logic      rst,
    input  bank_vec_t level,
    input  bank_vec_t dir,
    input  bank_vec_t rise_en,
    input  bank_vec_t fall_en,
    input  logic      clr_hit,
    input  bank_vec_t clr_mask,
    output bank_vec_t status,
    output logic      wake_hit
);
    localparam bank_vec_t PRESENT = present_set(BANK_IDX, NUM_LINES);
    localparam bank_vec_t WAKEUP  = wake_set(BANK_IDX) & PRESENT;

    bank_vec_t prev;
    bank_vec_t live_in;
    bank_vec_t clr_bits;
    edge_evt_t evt;

    always_comb begin
        live_in  = ~dir & PRESENT;
        evt.rise = level & ~prev & rise_en & live_in;
        evt.fall = ~level & prev & fall_en & live_in;
        clr_bits = clr_hit ? clr_mask : '0;
        wake_hit = |((level ^ prev) & ~dir & WAKEUP);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev   <= '0;
            status <= '0;
        end else begin
            prev   <= level;
            status <= (status & ~clr_bits) | evt.rise | evt.fall;
        end
    end
endmodule

// File: rtl/gpio_irq_fold.sv
module gpio_irq_fold #(
    parameter int NPINS  = 128,
    parameter int NBANKS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NPINS-1:0]  status,
    input  logic [NBANKS-1:0] wake_hits,
    input  logic              halted,
    output logic              irq_pin0,
    output logic              irq_pin1,
    output logic              irq_shared,
    output logic              wake_req
);
    always_ff @(posedge clk) begin
        if (rst) begin
            irq_pin0   <= 1'b0;
            irq_pin1   <= 1'b0;
            irq_shared <= 1'b0;
            wake_req   <= 1'b0;
        end else begin
            irq_pin0   <= status[0];
            irq_pin1   <= status[1];
            irq_shared <= |status[NPINS-1:2];
            wake_req   <= halted & (|wake_hits);
        end
    end
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
    import gpio_edge_pkg::*;
#(
    parameter int NUM_BANKS = DEF_BANKS,
    parameter int NUM_LINES = 121,
    parameter int SEL_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_BANKS*BANK_W-1:0]   pin_in,
    input  logic [NUM_BANKS*BANK_W-1:0]   pin_dir,
    input  logic [NUM_BANKS*BANK_W-1:0]   rise_en,
    input  logic [NUM_BANKS*BANK_W-1:0]   fall_en,
    input  logic                          clr_valid,
    input  logic [SEL_W-1:0]              clr_bank,
    input  logic [BANK_W-1:0]             clr_mask,
    input  logic                          halted,
    output logic [NUM_BANKS*BANK_W-1:0]   status_out,
    output logic                          irq_pin0,
    output logic                          irq_pin1,
    output logic                          irq_shared,
    output logic                          wake_req
);
    localparam int NPINS = NUM_BANKS * BANK_W;

    logic [NPINS-1:0]     level_s;
    logic [NUM_BANKS-1:0] wake_hits;

    gpio_sync2 #(.W(NPINS)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (level_s)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        gpio_edge_bank #(
            .BANK_IDX  (b),
            .NUM_LINES (NUM_LINES)
        ) u_bank (
            .clk      (clk),
            .rst      (rst),
            .level    (level_s[b*BANK_W +: BANK_W]),
            .dir      (pin_dir[b*BANK_W +: BANK_W]),
            .rise_en  (rise_en[b*BANK_W +: BANK_W]),
            .fall_en  (fall_en[b*BANK_W +: BANK_W]),
            .clr_hit  (clr_valid && (clr_bank == SEL_W'(b))),
            .clr_mask (clr_mask),
            .status   (status_out[b*BANK_W +: BANK_W]),
            .wake_hit (wake_hits[b])
        );
    end

    gpio_irq_fold #(.NPINS(NPINS), .NBANKS(NUM_BANKS)) u_fold (
        .clk        (clk),
        .rst        (rst),
        .status     (status_out),
        .wake_hits  (wake_hits),
        .halted     (halted),
        .irq_pin0   (irq_pin0),
        .irq_pin1   (irq_pin1),
        .irq_shared (irq_shared),
        .wake_req   (wake_req)
    );
endmodule

// File: rtl/gpio_edge_irq_chk.sv
module gpio_edge_irq_chk #(
    parameter int NPINS     = 128,
    parameter int NUM_LINES = 121
) (
    input logic             clk,
    input logic             rst,
    input logic             dir0,
    input logic             halted,
    input logic [NPINS-1:0] status_out,
    input logic             irq_pin0,
    input logic             irq_pin1,
    input logic             irq_shared,
    input logic             wake_req
);
    logic alive;

    always_ff @(posedge clk) begin
        if (rst) alive <= 1'b0;
        else     alive <= 1'b1;
    end

    assert_irq0_follow_R6: assert property (@(posedge clk) disable iff (rst)
        alive |-> (irq_pin0 == $past(status_out[0])));

    assert_irq1_follow_R6: assert property (@(posedge clk) disable iff (rst)
        alive |-> (irq_pin1 == $past(status_out[1])));

    assert_shared_or_R7: assert property (@(posedge clk) disable iff (rst)
        alive |-> (irq_shared == $past(|status_out[NPINS-1:2])));

    assert_wake_needs_halt_R8: assert property (@(posedge clk) disable iff (rst)
        (alive && wake_req) |-> $past(halted));

    assert_output_no_capture_R3: assert property (@(posedge clk) disable iff (rst)
        (alive && $rose(status_out[0])) |-> !$past(dir0));

    assert_absent_pins_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        alive |-> ((status_out >> NUM_LINES) == '0));
endmodule

bind gpio_edge_irq gpio_edge_irq_chk #(
    .NPINS     (NUM_BANKS * gpio_edge_pkg::BANK_W),
    .NUM_LINES (NUM_LINES)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .dir0       (pin_dir[0]),
    .halted     (halted),
    .status_out (status_out),
    .irq_pin0   (irq_pin0),
    .irq_pin1   (irq_pin1),
    .irq_shared (irq_shared),
    .wake_req   (wake_req)
);

// File: tb/test_gpio_edge_irq.sv
`timescale 1ns/1ps
module test_gpio_edge_irq;
    localparam int NP = 128;

    logic          clk = 1'b0;
    logic          rst;
    logic [NP-1:0] pin_in, pin_dir, rise_en, fall_en;
    logic          clr_valid;
    logic [1:0]    clr_bank;
    logic [31:0]   clr_mask;
    logic          halted;
    logic [NP-1:0] status_out;
    logic          irq_pin0, irq_pin1, irq_shared, wake_req;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    gpio_edge_irq i_gpio_edge_irq (
        .clk(clk), .rst(rst), .pin_in(pin_in), .pin_dir(pin_dir),
        .rise_en(rise_en), .fall_en(fall_en), .clr_valid(clr_valid),
        .clr_bank(clr_bank), .clr_mask(clr_mask), .halted(halted),
        .status_out(status_out), .irq_pin0(irq_pin0), .irq_pin1(irq_pin1),
        .irq_shared(irq_shared), .wake_req(wake_req)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [NP-1:0] act,
                         input logic [NP-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_all();
        for (int b = 0; b < 4; b++) begin
            clr_valid = 1'b1; clr_bank = 2'(b); clr_mask = '1;
            tick(1);
        end
        clr_valid = 1'b0; clr_mask = '0;
        tick(1);
    endtask

    task automatic t_reset();
        check("R10 status after reset", status_out, '0);
        check("R10 irqs after reset", {irq_pin0, irq_pin1, irq_shared, wake_req}, '0);
    endtask

    task automatic t_rise();
        rise_en[5] = 1'b1;
        pin_in[5]  = 1'b1;
        tick(2);
        check("R1 status not yet set after two edges", status_out[5], 1'b0);
        tick(1);
        check("R1 rising edge captured", status_out, 128'h20);
        check("R7 shared irq not yet", irq_shared, 1'b0);
        tick(1);
        check("R7 shared irq raised", irq_shared, 1'b1);
        check("R6 pin0 irq stays low", irq_pin0, 1'b0);
        clr_valid = 1'b1; clr_bank = 2'd0; clr_mask = 32'h20;
        tick(1);
        clr_valid = 1'b0;
        check("R4 clear bit 5", status_out, '0);
        tick(1);
        check("R7 shared irq drops after clear", irq_shared, 1'b0);
    endtask

    task automatic t_clear_select();
        rise_en[0] = 1'b1; rise_en[6] = 1'b1;
        pin_in[0]  = 1'b1; pin_in[6]  = 1'b1;
        tick(3);
        check("R1 pins 0 and 6 captured", status_out, 128'h41);
        clr_valid = 1'b1; clr_bank = 2'd1; clr_mask = 32'h41;
        tick(1);
        check("R4 other bank clear leaves bank 0", status_out, 128'h41);
        check("R6 pin0 irq raised", irq_pin0, 1'b1);
        clr_bank = 2'd0; clr_mask = 32'h40;
        tick(1);
        clr_valid = 1'b0;
        check("R4 zero mask bits untouched", status_out, 128'h1);
        clear_all();
        check("R6 pin0 irq drops", irq_pin0, 1'b0);
    endtask

    task automatic t_fall();
        fall_en[1] = 1'b1; fall_en[70] = 1'b1;
        pin_in[1]  = 1'b1; pin_in[70]  = 1'b1;
        tick(3);
        check("R2 rising ignored without rise enable", status_out, '0);
        pin_in[1] = 1'b0; pin_in[70] = 1'b0;
        tick(3);
        check("R2 falling captured", status_out, (128'h1 << 70) | 128'h2);
        tick(1);
        check("R6 pin1 irq raised", {irq_pin0, irq_pin1}, 2'b01);
        clear_all();
    endtask

    task automatic t_dir();
        pin_dir[40] = 1'b1; rise_en[40] = 1'b1; fall_en[40] = 1'b1;
        pin_dir[0]  = 1'b1;
        pin_in[40]  = 1'b1; pin_in[0] = 1'b0;
        tick(4);
        pin_in[40] = 1'b0; pin_in[0] = 1'b1;
        tick(4);
        check("R3 output pins never capture", status_out, '0);
        pin_dir[40] = 1'b0; pin_dir[0] = 1'b0;
        pin_in[0] = 1'b0;
        tick(4);
        clear_all();
    endtask

    task automatic t_edge_wins();
        rise_en[10] = 1'b1; fall_en[10] = 1'b1;
        pin_in[10] = 1'b1;
        tick(3);
        pin_in[10] = 1'b0;
        tick(2);
        clr_valid = 1'b1; clr_bank = 2'd0; clr_mask = 32'h400;
        tick(1);
        clr_valid = 1'b0;
        check("R5 edge beats same-cycle clear", status_out, 128'h400);
        clear_all();
        check("R4 later clear succeeds", status_out, '0);
    endtask

    task automatic t_absent();
        rise_en[125] = 1'b1; pin_in[125] = 1'b1;
        rise_en[120] = 1'b1; pin_in[120] = 1'b1;
        tick(3);
        check("R9 pin 125 ignored, pin 120 kept", status_out, 128'h1 << 120);
        clear_all();
    endtask

    task automatic t_wake();
        halted = 1'b1;
        pin_in[3] = 1'b1;
        tick(2);
        check("R8 no wake before capture edge", wake_req, 1'b0);
        tick(1);
        check("R8 wake on wake-capable pin 3", wake_req, 1'b1);
        tick(1);
        check("R8 wake is a single pulse", wake_req, 1'b0);
        pin_in[2] = 1'b1;
        tick(3);
        check("R8 pin 2 not wake-capable", wake_req, 1'b0);
        pin_dir[4] = 1'b1; pin_in[4] = 1'b1;
        tick(3);
        check("R8 output pin gives no wake", wake_req, 1'b0);
        halted = 1'b0;
        pin_in[3] = 1'b0;
        tick(3);
        check("R8 no wake when not halted", wake_req, 1'b0);
        halted = 1'b1;
        pin_in[116] = 1'b1;
        tick(3);
        check("R8 wake on bank 3 pin 116", wake_req, 1'b1);
        halted = 1'b0;
        tick(1);
    endtask

    initial begin
        #1ms;
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL R10 watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        pin_in = '0; pin_dir = '0; rise_en = '0; fall_en = '0;
        clr_valid = 1'b0; clr_bank = '0; clr_mask = '0; halted = 1'b0;
        tick(4);
        rst = 1'b0;
        tick(1);
        t_reset();
        t_rise();
        t_clear_select();
        t_fall();
        t_dir();
        t_edge_wins();
        t_absent();
        t_wake();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule